// File: doc/BRIEF.md
# One-Hot Step Sequencer with Selectable Cycle Length

The block has ten step outputs and keeps exactly one of them high at any time. On each rising clock edge the high output moves up by one position. After the last step it returns to step 0. A four-bit length input sets how many steps make up the cycle. Examples are two steps for a coin toss, six for a die and ten for a full sweep. The return to step 0 is decided synchronously from the current step and the length, so the first step past the end is never driven high.

An active-high freeze input holds the current step for as long as it stays high. A second output group merges steps onto fewer indicator lines through an OR stage set by a parameter. By default step s drives indicator s mod 6. One full cycle takes length × clock period; for example, ten steps at 20 Hz take 0.5 s. The clock source, switch debouncing and lamp drive are outside the block.

Top module: `step_sequencer`

## Requirements
- R1: Outside reset, exactly one bit of `step_o` is high in every cycle.
- R2: Reset is asynchronous and active high. As soon as `rst` rises, `step_o` equals 10'b00_0000_0001, and it stays at that value on every clock edge while `rst` is high.
- R3: With `freeze` low and `cyc_len` = 10, each rising edge moves the high bit from `step_o[k]` to `step_o[k+1]`, and `step_o[9]` is followed by `step_o[0]`.
- R4: With `cyc_len` = L (1 to 10) and `freeze` low, the steps run 0, 1, …, L−1 and then 0 again. `step_o[L]` is never high. With L = 1, `step_o[0]` stays high.
- R5: A `cyc_len` code of 0, or any code from 11 to 15, acts as a length of 10.
- R6: While `freeze` is high, `step_o` keeps its value across edges. This includes the last step of the cycle, which does not wrap while frozen. Stepping resumes on the first edge after `freeze` goes low.
- R7: If the current step index is at or above the length (for example because `cyc_len` was lowered), the next edge returns to step 0 even when `freeze` is high.
- R8: Indicator `lamp_o[j]` is the OR of every step output that is mapped to it. With the default map, step s drives indicator s mod 6, so exactly one indicator is lit in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; steps advance on the rising edge |
| rst | input | 1 | Asynchronous active-high reset to step 0 |
| freeze | input | 1 | High holds the current step |
| cyc_len | input | 4 | Number of steps in the cycle (0 or above 10 means 10) |
| step_o | output | 10 | One-hot step outputs |
| lamp_o | output | 6 | Indicator lines, ORed from the step outputs |

## Verification
Two functions can meet in one cycle: the freeze hold and the synchronous return to step 0. The bench provokes this in two ways. First, it raises `freeze` while the sequencer sits on the last step of a short cycle. Each following sample must show that same step, and no wrap to step 0. Second, it lowers `cyc_len` below the current step while `freeze` is high. Here the next sample must show step 0, because a step beyond the cycle must not be held.

// File: rtl/stepseq_pkg.sv
`timescale 1ns/1ps
package stepseq_pkg;

  // Length codes outside 1..steps select the full cycle.
  function automatic int unsigned clamp_len(int unsigned raw, int unsigned steps);
    if (raw == 0 || raw > steps) return steps;
    return raw;
  endfunction

  // Default indicator assignment: step s lights indicator s mod lamps.
  function automatic int unsigned lamp_of_step(int unsigned s, int unsigned lamps);
    return s % lamps;
  endfunction

endpackage

// File: rtl/stepseq_restart.sv
`timescale 1ns/1ps
module stepseq_restart #(
  parameter int NUM_STEPS = 10,
  parameter int LEN_W     = 4
) (
  input  logic [NUM_STEPS-1:0] step_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic                 at_last_o,
  output logic                 beyond_o
);
  import stepseq_pkg::*;

  int unsigned             eff_len;
  logic [NUM_STEPS-1:0]    last_mask;
  logic [NUM_STEPS-1:0]    over_mask;

  always_comb begin
    eff_len = clamp_len(int'(len_i), NUM_STEPS);
    for (int i = 0; i < NUM_STEPS; i++) begin
      last_mask[i] = (i == int'(eff_len) - 1);
      over_mask[i] = (i >  int'(eff_len) - 1);
    end
  end

  assign at_last_o = |(step_i & last_mask);
  assign beyond_o  = |(step_i & over_mask);

endmodule

// File: rtl/stepseq_ring.sv
`timescale 1ns/1ps
module stepseq_ring #(
  parameter int NUM_STEPS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 freeze,
  input  logic                 at_last,
  input  logic                 beyond,
  output logic [NUM_STEPS-1:0] state_o
);
  localparam logic [NUM_STEPS-1:0] FIRST = {{(NUM_STEPS-1){1'b0}}, 1'b1};

  logic [NUM_STEPS-1:0] state_q;
  logic                 legal;
  logic                 hold_ev;
  logic                 wrap_ev;

  assign legal   = ($countones(state_q) == 1);
  assign hold_ev = freeze && !beyond;
  assign wrap_ev = (at_last || beyond) && !hold_ev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           state_q <= FIRST;
    else if (!legal)   state_q <= FIRST;
    else if (hold_ev)  state_q <= state_q;
    else if (wrap_ev)  state_q <= FIRST;
    else               state_q <= state_q << 1;
  end

  assign state_o = state_q;

  // R1
  p_one_hot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  // R6
  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (freeze && !beyond && legal) |=> $stable(state_q));

  // R3
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !at_last && !beyond && legal) |=> state_q == ($past(state_q) << 1));

  // R4 / R7
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    ((at_last && !freeze) || beyond) |=> state_q == FIRST);

endmodule

// File: rtl/stepseq_lamps.sv
`timescale 1ns/1ps
module stepseq_lamps #(
  parameter int NUM_STEPS = 10,
  parameter int NUM_LAMPS = 6,
  parameter logic [NUM_LAMPS*NUM_STEPS-1:0] LAMP_MAP = '0
) (
  input  logic [NUM_STEPS-1:0] step_i,
  output logic [NUM_LAMPS-1:0] lamp_o
);
  import stepseq_pkg::*;

  localparam bit USE_MOD = (LAMP_MAP == '0);

  function automatic logic [NUM_STEPS-1:0] col_mask(int j);
    logic [NUM_STEPS-1:0] m;
    for (int s = 0; s < NUM_STEPS; s++) begin
      if (USE_MOD) m[s] = (lamp_of_step(s, NUM_LAMPS) == j);
      else         m[s] = LAMP_MAP[j*NUM_STEPS + s];
    end
    return m;
  endfunction

  for (genvar j = 0; j < NUM_LAMPS; j++) begin : g_lamp
    localparam logic [NUM_STEPS-1:0] MASK = col_mask(j);
    assign lamp_o[j] = |(step_i & MASK);
  end

endmodule

// File: rtl/step_sequencer.sv
`timescale 1ns/1ps
module step_sequencer #(
  parameter int NUM_STEPS = 10,
  parameter int NUM_LAMPS = 6,
  parameter int LEN_W     = $clog2(NUM_STEPS + 1),
  parameter logic [NUM_LAMPS*NUM_STEPS-1:0] LAMP_MAP = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 freeze,
  input  logic [LEN_W-1:0]     cyc_len,
  output logic [NUM_STEPS-1:0] step_o,
  output logic [NUM_LAMPS-1:0] lamp_o
);

  logic [NUM_STEPS-1:0] state;
  logic                 at_last;
  logic                 beyond;

  stepseq_restart #(.NUM_STEPS(NUM_STEPS), .LEN_W(LEN_W)) u_restart (
    .step_i    (state),
    .len_i     (cyc_len),
    .at_last_o (at_last),
    .beyond_o  (beyond)
  );

  stepseq_ring #(.NUM_STEPS(NUM_STEPS)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .at_last (at_last),
    .beyond  (beyond),
    .state_o (state)
  );

  stepseq_lamps #(.NUM_STEPS(NUM_STEPS), .NUM_LAMPS(NUM_LAMPS), .LAMP_MAP(LAMP_MAP)) u_lamps (
    .step_i (state),
    .lamp_o (lamp_o)
  );

  assign step_o = state;

  // R8: with the default map exactly one indicator follows the single step
  p_lamp_single_r8: assert property (@(posedge clk) disable iff (rst)
    (LAMP_MAP != '0) || ($countones(lamp_o) == 1));

endmodule

// File: tb/step_sequencer_test.sv
`timescale 1ns/1ps
module step_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       freeze = 1'b0;
  logic [3:0] cyc_len = 4'd10;
  logic [9:0] step_o;
  logic [5:0] lamp_o;

  int n_cmp = 0;
  int n_bad = 0;
  int model = 0;

  always #5 clk = ~clk;

  step_sequencer uut (
    .clk(clk), .rst(rst), .freeze(freeze), .cyc_len(cyc_len),
    .step_o(step_o), .lamp_o(lamp_o)
  );

  function automatic int nxt(int idx, int l, bit f);
    int L;
    L = (l == 0 || l > 10) ? 10 : l;
    if (idx > L - 1) return 0;
    if (f) return idx;
    if (idx == L - 1) return 0;
    return idx + 1;
  endfunction

  task automatic check(string tag);
    logic [9:0] es;
    logic [5:0] el;
    es = 10'b1 << model;
    el = 6'b1 << (model % 6);
    n_cmp++;
    if (step_o !== es || lamp_o !== el || $countones(step_o) != 1) begin
      n_bad++;
      $display("FAIL %s: step=%b exp=%b lamp=%b exp=%b", tag, step_o, es, lamp_o, el);
    end
  endtask

  task automatic tick(int l, bit f, string tag);
    cyc_len = 4'(l);
    freeze  = f;
    @(posedge clk);
    model = nxt(model, l, f);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model = 0;
    #1;
    check("R2 async");
    @(posedge clk);
    @(negedge clk);
    check("R2 held");
    rst = 1'b0;
    freeze = 1'b0;
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 23; i++) tick(10, 1'b0, "R3 full cycle");
  endtask

  task automatic t_short();
    do_reset();
    for (int i = 0; i < 7; i++) tick(2, 1'b0, "R4 len2");
    do_reset();
    for (int i = 0; i < 15; i++) tick(6, 1'b0, "R4 len6");
    do_reset();
    for (int i = 0; i < 4; i++) tick(1, 1'b0, "R4 len1");
  endtask

  task automatic t_range();
    do_reset();
    for (int i = 0; i < 12; i++) tick(0, 1'b0, "R5 code0");
    do_reset();
    for (int i = 0; i < 12; i++) tick(13, 1'b0, "R5 code13");
  endtask

  task automatic t_freeze();
    do_reset();
    for (int i = 0; i < 3; i++) tick(10, 1'b0, "R6 run");
    for (int i = 0; i < 4; i++) tick(10, 1'b1, "R6 frozen");
    tick(10, 1'b0, "R6 resume");
    do_reset();
    for (int i = 0; i < 3; i++) tick(4, 1'b0, "R6 to last");
    for (int i = 0; i < 3; i++) tick(4, 1'b1, "R6 frozen at last");
    tick(4, 1'b0, "R6 wrap after release");
  endtask

  task automatic t_shrink();
    do_reset();
    for (int i = 0; i < 7; i++) tick(10, 1'b0, "R7 run");
    tick(3, 1'b1, "R7 beyond while frozen");
    tick(3, 1'b0, "R7 continue");
  endtask

  task automatic t_lamps();
    do_reset();
    for (int i = 0; i < 12; i++) tick(10, 1'b0, "R8 R1 lamps");
  endtask

  initial begin
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 power-up");
    rst = 1'b0;
    t_full();
    t_short();
    t_range();
    t_freeze();
    t_shrink();
    t_lamps();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule